// File: doc/BRIEF.md
# Configurable SPI Shift Engine

A full-duplex serial transfer engine that exchanges one word with a peer per transfer. The same block works as the bus master, where it makes the serial clock from the system clock and drives the select line, or as a slave, where it follows an external serial clock and select after synchronising them. Clock idle level, clock phase, bit order (LSB or MSB first) and word size (8 or 16 bits) are chosen by static configuration inputs.

Software-side access is modelled as strobes. A write of the transmit word loads the shift register and, in master mode, starts the transfer. The received word sits in a separate data register that changes only when a transfer ends. A completion flag is raised at that point and is cleared by a status read followed by a data access.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the completion flag is 0, the received word is 0, busy is 0, the select output is high, the serial output is 0 and the serial clock sits at the level of `cfg_cpol`.
- R2: While no transfer is running, the serial clock output stays at `cfg_cpol` (0 = idle low, 1 = idle high). The clock polarity does not change which edges sample and which edges shift.
- R3: A transfer produces exactly 2n serial clock transitions, with n = 16 when `cfg_wide` is 1 and n = 8 when it is 0.
- R4: When a master and a slave copy of the block are connected, after one transfer each holds in `rx_data` the other's transmit word (lower n bits, upper bits 0), for all four polarity/phase combinations.
- R5: With `cfg_lsb_first` = 0 the first bit on the line is bit n-1 and later bits go downward. With 1 the first bit is bit 0 and later bits go upward. Incoming bits are assembled in the same order.
- R6: With `cfg_cpha` = 0 the sample edges are the odd transitions, and the first bit is on the serial output before the first clock transition. With `cfg_cpha` = 1 the sample edges are the even transitions, and the serial output stays 0 until the first transition.
- R7: In master mode each clock half-period lasts `cfg_half_div` system clocks. The select output falls at least one half-period before the first transition and rises no earlier than one half-period after the last. The clock only toggles while select is low.
- R8: `rx_data` keeps its previous value for the whole transfer and changes only in the cycle in which the completion flag is set.
- R9: The completion flag is set when the final transition has been processed. A data access (`data_rd` or `tx_wr`) alone does not clear it. A `stat_rd` while the flag is set, followed by a later data access, clears it.
- R10: A `tx_wr` while `busy` is 1 is ignored and does not alter the word being sent.
- R11: In master mode the serial output is 0 whenever no transfer is running. In slave mode the select output is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = sample on odd edges, 1 = sample on even edges |
| cfg_lsb_first | input | 1 | 1 = bit 0 first |
| cfg_wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| cfg_half_div | input | DIV_W | System clocks per serial clock half-period (master) |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_data | input | 16 | Transmit word |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_data | output | 16 | Received word register |
| done_flag | output | 1 | Completion flag |
| busy | output | 1 | Transfer in progress (master running, or slave selected) |
| sck_o | output | 1 | Serial clock out (master) |
| ss_o | output | 1 | Select out, active low (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_i | input | 1 | Select in, active low (slave) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The assertions assume that the configuration inputs change only while the block is idle. They also assume that in slave mode the external clock half-period is longer than the two-stage synchroniser delay plus one cycle. Otherwise an edge can be missed or the reply bit can arrive late at the master. The bench changes configuration only between transfers and draws `cfg_half_div` from 6 to 12. A master and a slave copy share that divider, which keeps the slave's reply inside the master's sampling window.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int MAX_W    = 16;
    localparam int NARROW_W = 8;
    localparam int CNT_W    = $clog2(2 * MAX_W) + 1;

    typedef enum logic [1:0] {
        M_IDLE,
        M_LEAD,
        M_RUN,
        M_TRAIL
    } mstate_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic wide;
    } xfer_cfg_t;

    // Number of serial clock transitions in one transfer.
    function automatic logic [CNT_W-1:0] edge_total(input logic wide);
        return wide ? CNT_W'(2 * MAX_W) : CNT_W'(2 * NARROW_W);
    endfunction

    // Move one received bit into the shift register in the selected order.
    function automatic logic [MAX_W-1:0] shift_in(input logic [MAX_W-1:0] sh,
                                                  input logic b,
                                                  input logic lsb,
                                                  input logic wide);
        logic [MAX_W-1:0] r;
        if (!lsb) begin
            r = {sh[MAX_W-2:0], b};
        end else begin
            r = {1'b0, sh[MAX_W-1:1]};
            if (wide) begin
                r[MAX_W-1] = b;
            end else begin
                r[NARROW_W-1]       = b;
                r[MAX_W-1:NARROW_W] = sh[MAX_W-1:NARROW_W];
            end
        end
        return r;
    endfunction

    // Bit presented on the serial output.
    function automatic logic out_bit(input logic [MAX_W-1:0] sh,
                                     input logic lsb,
                                     input logic wide);
        if (lsb)
            return sh[0];
        return wide ? sh[MAX_W-1] : sh[NARROW_W-1];
    endfunction

    function automatic logic [MAX_W-1:0] word_mask(input logic [MAX_W-1:0] d,
                                                   input logic wide);
        return wide ? d : {{(MAX_W-NARROW_W){1'b0}}, d[NARROW_W-1:0]};
    endfunction

endpackage

// File: rtl/spi_master_clkgen.sv
module spi_master_clkgen
    import spi_eng_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic [CNT_W-1:0] total,
    input  logic             cpol,
    output logic             sck,
    output logic             ss_n,
    output logic             busy,
    output logic             edge_stb,
    output logic [CNT_W-1:0] edge_num
);

    mstate_e          state_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] hd;
    logic             phase_q;
    logic [CNT_W-1:0] num_q;
    logic             stb_q;
    logic             ss_q;

    assign hd = (half_div == '0) ? DIV_W'(1) : half_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= M_IDLE;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            num_q   <= '0;
            stb_q   <= 1'b0;
            ss_q    <= 1'b1;
        end else begin
            stb_q <= 1'b0;
            case (state_q)
                M_IDLE: begin
                    if (start) begin
                        state_q <= M_LEAD;
                        ss_q    <= 1'b0;
                        cnt_q   <= hd - 1'b1;
                        num_q   <= '0;
                        phase_q <= 1'b0;
                    end
                end
                M_LEAD, M_RUN: begin
                    if (cnt_q == '0) begin
                        phase_q <= ~phase_q;
                        num_q   <= num_q + 1'b1;
                        stb_q   <= 1'b1;
                        cnt_q   <= hd - 1'b1;
                        if (num_q + 1'b1 == total)
                            state_q <= M_TRAIL;
                        else
                            state_q <= M_RUN;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                M_TRAIL: begin
                    if (cnt_q == '0) begin
                        ss_q    <= 1'b1;
                        state_q <= M_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= M_IDLE;
            endcase
        end
    end

    assign sck      = cpol ^ phase_q;
    assign ss_n     = ss_q;
    assign busy     = (state_q != M_IDLE);
    assign edge_stb = stb_q;
    assign edge_num = num_q;

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
    import spi_eng_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_i,
    input  logic             ss_n_i,
    input  logic             sdi_i,
    input  logic [CNT_W-1:0] total,
    output logic             sdi_s,
    output logic             selected,
    output logic             start,
    output logic             edge_stb,
    output logic [CNT_W-1:0] edge_num
);

    logic [SYNC_STAGES-1:0] sck_ff, ss_ff, sdi_ff;
    logic                   sck_p, ss_p;
    logic [CNT_W-1:0]       cnt_q;
    logic                   sck_s, ss_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_ff <= '0;
            ss_ff  <= '1;
            sdi_ff <= '0;
            sck_p  <= 1'b0;
            ss_p   <= 1'b1;
        end else begin
            sck_ff <= {sck_ff[SYNC_STAGES-2:0], sck_i};
            ss_ff  <= {ss_ff[SYNC_STAGES-2:0], ss_n_i};
            sdi_ff <= {sdi_ff[SYNC_STAGES-2:0], sdi_i};
            sck_p  <= sck_s;
            ss_p   <= ss_s;
        end
    end

    assign sck_s    = sck_ff[SYNC_STAGES-1];
    assign ss_s     = ss_ff[SYNC_STAGES-1];
    assign sdi_s    = sdi_ff[SYNC_STAGES-1];
    assign selected = !ss_s;
    assign start    = ss_p && !ss_s;
    assign edge_stb = selected && (sck_s != sck_p) && (cnt_q < total);
    assign edge_num = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !selected)
            cnt_q <= '0;
        else if (edge_stb)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  xfer_cfg_t        cfg,
    input  logic             load,
    input  logic [MAX_W-1:0] load_data,
    input  logic             start,
    input  logic             edge_stb,
    input  logic [CNT_W-1:0] edge_num,
    input  logic             sdi,
    output logic             sdo_bit,
    output logic             done_stb,
    output logic [MAX_W-1:0] result
);

    logic [MAX_W-1:0] sh_q;
    logic             samp_q;
    logic             drive_q;
    logic             done_q;
    logic             is_samp;
    logic             is_last;
    logic [CNT_W-1:0] total;

    assign total   = edge_total(cfg.wide);
    assign is_samp = cfg.cpha ? !edge_num[0] : edge_num[0];
    assign is_last = (edge_num == total);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            samp_q  <= 1'b0;
            drive_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load)
                sh_q <= load_data;
            if (start)
                drive_q <= !cfg.cpha;
            if (edge_stb) begin
                if (is_samp) begin
                    if (is_last) begin
                        // phase 1: the last edge samples and commits at once
                        sh_q    <= shift_in(sh_q, sdi, cfg.lsb_first, cfg.wide);
                        done_q  <= 1'b1;
                        drive_q <= 1'b0;
                    end else begin
                        samp_q <= sdi;
                    end
                end else if (cfg.cpha && edge_num == CNT_W'(1)) begin
                    drive_q <= 1'b1;
                end else begin
                    sh_q <= shift_in(sh_q, samp_q, cfg.lsb_first, cfg.wide);
                    if (is_last) begin
                        done_q  <= 1'b1;
                        drive_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign sdo_bit  = drive_q & out_bit(sh_q, cfg.lsb_first, cfg.wide);
    assign done_stb = done_q;
    assign result   = word_mask(sh_q, cfg.wide);

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_master,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             cfg_wide,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             tx_wr,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             stat_rd,
    input  logic             data_rd,
    output logic [MAX_W-1:0] rx_data,
    output logic             done_flag,
    output logic             busy,
    output logic             sck_o,
    output logic             ss_o,
    input  logic             sck_i,
    input  logic             ss_i,
    input  logic             sdi,
    output logic             sdo
);

    xfer_cfg_t        cfg;
    logic [CNT_W-1:0] total;
    logic             load;
    logic             m_start, m_sck, m_ss_n, m_busy, m_stb;
    logic [CNT_W-1:0] m_num;
    logic             s_sdi, s_sel, s_start, s_stb;
    logic [CNT_W-1:0] s_num;
    logic             c_start, c_stb, c_sdi, c_sdo, c_done;
    logic [CNT_W-1:0] c_num;
    logic [MAX_W-1:0] c_result;
    logic [MAX_W-1:0] rx_q;
    logic             flag_q, armed_q;

    assign cfg   = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first, wide: cfg_wide};
    assign total = edge_total(cfg_wide);
    assign busy  = cfg_master ? m_busy : s_sel;
    assign load  = tx_wr && !busy;
    assign m_start = load && cfg_master;

    spi_master_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk      (clk),
        .rst      (rst),
        .start    (m_start),
        .half_div (cfg_half_div),
        .total    (total),
        .cpol     (cfg_cpol),
        .sck      (m_sck),
        .ss_n     (m_ss_n),
        .busy     (m_busy),
        .edge_stb (m_stb),
        .edge_num (m_num)
    );

    spi_slave_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk      (clk),
        .rst      (rst),
        .sck_i    (sck_i),
        .ss_n_i   (ss_i),
        .sdi_i    (sdi),
        .total    (total),
        .sdi_s    (s_sdi),
        .selected (s_sel),
        .start    (s_start),
        .edge_stb (s_stb),
        .edge_num (s_num)
    );

    assign c_start = cfg_master ? m_start : s_start;
    assign c_stb   = cfg_master ? m_stb   : s_stb;
    assign c_num   = cfg_master ? m_num   : s_num;
    assign c_sdi   = cfg_master ? sdi     : s_sdi;

    spi_shift_core core_i (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .load      (load),
        .load_data (tx_data),
        .start     (c_start),
        .edge_stb  (c_stb),
        .edge_num  (c_num),
        .sdi       (c_sdi),
        .sdo_bit   (c_sdo),
        .done_stb  (c_done),
        .result    (c_result)
    );

    // Receive register and completion flag with its two-step clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= '0;
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (stat_rd && flag_q)
                armed_q <= 1'b1;
            if ((data_rd || tx_wr) && armed_q) begin
                flag_q  <= 1'b0;
                armed_q <= 1'b0;
            end
            if (c_done) begin
                rx_q    <= c_result;
                flag_q  <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end

    assign rx_data   = rx_q;
    assign done_flag = flag_q;
    assign sck_o     = cfg_master ? m_sck : cfg_cpol;
    assign ss_o      = cfg_master ? m_ss_n : 1'b1;
    assign sdo       = cfg_master ? c_sdo : (s_sel & c_sdo);

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_master,
    input logic        cfg_cpol,
    input logic        tx_wr,
    input logic        data_rd,
    input logic [15:0] rx_data,
    input logic        done_flag,
    input logic        busy,
    input logic        sck_o,
    input logic        ss_o,
    input logic        sdo
);

    // R2: idle clock level follows polarity
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && !busy) |-> (sck_o == cfg_cpol));

    // R7: clock moves only inside a selected frame
    assert_sck_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && $stable(cfg_cpol) && !$stable(sck_o)) |-> !ss_o);

    // R8: receive register only changes together with a set flag
    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> done_flag);

    // R9: the flag only drops right after a data access
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(done_flag) |-> $past(data_rd || tx_wr));

    // R11: master output idles low; slave never drives select low
    assert_sdo_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && !busy) |-> (sdo == 1'b0));

    assert_slave_ss_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg_master |-> ss_o);

endmodule

bind spi_xfer_engine spi_xfer_engine_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_master (cfg_master),
    .cfg_cpol   (cfg_cpol),
    .tx_wr      (tx_wr),
    .data_rd    (data_rd),
    .rx_data    (rx_data),
    .done_flag  (done_flag),
    .busy       (busy),
    .sck_o      (sck_o),
    .ss_o       (ss_o),
    .sdo        (sdo)
);

// File: tb/spi_xfer_engine_tb_top.sv
module spi_xfer_engine_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        cpol = 0, cpha = 0, lsb = 0, wide = 0;
    logic [7:0]  div = 8'd6;
    logic        m_tx_wr = 0, m_stat = 0, m_drd = 0;
    logic        s_tx_wr = 0, s_stat = 0, s_drd = 0;
    logic [15:0] m_txd = 0, s_txd = 0;
    logic [15:0] m_rx, s_rx;
    logic        m_flag, s_flag, m_busy, s_busy;
    logic        m_sck, m_ss, m_sdo, s_sck, s_ss, s_sdo;

    spi_xfer_engine dut_i (
        .clk(clk), .rst(rst), .cfg_master(1'b1), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_lsb_first(lsb), .cfg_wide(wide), .cfg_half_div(div),
        .tx_wr(m_tx_wr), .tx_data(m_txd), .stat_rd(m_stat), .data_rd(m_drd),
        .rx_data(m_rx), .done_flag(m_flag), .busy(m_busy),
        .sck_o(m_sck), .ss_o(m_ss), .sck_i(1'b0), .ss_i(1'b1), .sdi(s_sdo), .sdo(m_sdo)
    );

    spi_xfer_engine slv_i (
        .clk(clk), .rst(rst), .cfg_master(1'b0), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_lsb_first(lsb), .cfg_wide(wide), .cfg_half_div(div),
        .tx_wr(s_tx_wr), .tx_data(s_txd), .stat_rd(s_stat), .data_rd(s_drd),
        .rx_data(s_rx), .done_flag(s_flag), .busy(s_busy),
        .sck_o(s_sck), .ss_o(s_ss), .sck_i(m_sck), .ss_i(m_ss), .sdi(m_sdo), .sdo(s_sdo)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] msk(input logic [15:0] d, input logic w);
        return w ? d : {8'h00, d[7:0]};
    endfunction

    function automatic logic first_bit(input logic [15:0] d, input logic l, input logic w, input logic ph);
        if (ph) return 1'b0;
        if (l) return d[0];
        return w ? d[15] : d[7];
    endfunction

    // line monitor
    bit          mon_on = 0;
    int          cyc = 0, edges = 0, ss_fall = 0, ss_rise = 0, first_e = 0, last_e = 0;
    bit          bad_iv = 0;
    logic        prev_sck = 0, prev_ss = 1, m_pre = 0, s_pre = 0;
    logic [15:0] mosi_w = 0, miso_w = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (!m_ss && prev_ss) ss_fall = cyc;
            if (m_ss && !prev_ss) ss_rise = cyc;
            if (m_sck != prev_sck) begin
                edges++;
                if (edges == 1) begin
                    first_e = cyc;
                    m_pre = m_sdo;
                    s_pre = s_sdo;
                end else if (cyc - last_e != int'(div)) begin
                    bad_iv = 1;
                end
                last_e = cyc;
                if ((edges % 2 == 1) != cpha) begin
                    if (lsb) begin
                        mosi_w[(edges-1)/2] = m_sdo;
                        miso_w[(edges-1)/2] = s_sdo;
                    end else begin
                        mosi_w = {mosi_w[14:0], m_sdo};
                        miso_w = {miso_w[14:0], s_sdo};
                    end
                end
            end
        end
        prev_sck = m_sck;
        prev_ss  = m_ss;
    end

    task automatic pulse_m(input int which);
        @(negedge clk);
        if (which == 0) m_stat = 1; else if (which == 1) m_drd = 1; else m_tx_wr = 1;
        @(negedge clk);
        m_stat = 0; m_drd = 0; m_tx_wr = 0;
    endtask

    task automatic pulse_s(input int which);
        @(negedge clk);
        if (which == 0) s_stat = 1; else if (which == 1) s_drd = 1; else s_tx_wr = 1;
        @(negedge clk);
        s_stat = 0; s_drd = 0; s_tx_wr = 0;
    endtask

    task automatic run_xfer(input logic cp, input logic ph, input logic lb, input logic wd,
                            input logic [7:0] dv, input logic [15:0] md, input logic [15:0] sd);
        logic [15:0] prev_rx;
        int          n;
        n = wd ? 16 : 8;
        @(negedge clk);
        cpol = cp; cpha = ph; lsb = lb; wide = wd; div = dv;
        repeat (2) @(negedge clk);
        chk(m_sck == cp, "R2 idle sck", m_sck, cp);
        s_txd = sd;
        pulse_s(2);
        edges = 0; bad_iv = 0; mosi_w = 0; miso_w = 0; mon_on = 1;
        prev_rx = m_rx;
        m_txd = md;
        pulse_m(2);
        repeat (int'(dv) * 4) @(negedge clk);
        m_txd = ~md;
        pulse_m(2);
        chk(m_busy == 1'b1, "R10 busy during transfer", m_busy, 1);
        chk(m_rx == prev_rx, "R8 rx held mid transfer", m_rx, prev_rx);
        while (m_busy || s_busy) @(negedge clk);
        repeat (8) @(negedge clk);
        mon_on = 0;
        chk(edges == 2 * n, "R3 edge count", edges, 2 * n);
        chk(m_rx == msk(sd, wd), "R4 master rx", m_rx, msk(sd, wd));
        chk(s_rx == msk(md, wd), "R4 R10 slave rx", s_rx, msk(md, wd));
        chk(mosi_w == msk(md, wd), "R5 master bit order", mosi_w, msk(md, wd));
        chk(miso_w == msk(sd, wd), "R5 slave bit order", miso_w, msk(sd, wd));
        chk(m_pre == first_bit(md, lb, wd, ph), "R6 master first bit", m_pre, first_bit(md, lb, wd, ph));
        chk(s_pre == first_bit(sd, lb, wd, ph), "R6 slave first bit", s_pre, first_bit(sd, lb, wd, ph));
        chk(first_e - ss_fall >= int'(dv), "R7 lead time", first_e - ss_fall, dv);
        chk(ss_rise - last_e >= int'(dv), "R7 trail time", ss_rise - last_e, dv);
        chk(!bad_iv, "R7 half period", bad_iv, 0);
        chk(m_flag && s_flag, "R9 flags set", {m_flag, s_flag}, 2'b11);
        chk(m_sdo == 1'b0 && s_ss == 1'b1, "R11 idle levels", {m_sdo, s_ss}, 2'b01);
        pulse_m(0); pulse_m(1);
        pulse_s(0); pulse_s(1);
        @(negedge clk);
        chk(!m_flag && !s_flag, "R9 flags cleared", {m_flag, s_flag}, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(m_flag == 0 && m_rx == 0 && m_busy == 0, "R1 master reset", {m_flag, m_rx, m_busy}, 0);
        chk(m_ss == 1 && m_sck == 0 && m_sdo == 0, "R1 master lines", {m_ss, m_sck, m_sdo}, 3'b100);
        chk(s_flag == 0 && s_rx == 0 && s_ss == 1, "R1 R11 slave reset", {s_flag, s_rx, s_ss}, 1);

        // directed: every mode, order and width
        for (int k = 0; k < 16; k++)
            run_xfer(k[0], k[1], k[2], k[3], 8'd6, 16'hA5C3 ^ 16'(k * 16'h1111), 16'h3C5A ^ 16'(k));

        // R9: data access alone does not clear the flag
        run_xfer(1, 0, 0, 1, 8'd7, 16'h8001, 16'h7FFE);
        m_txd = 16'h1234; s_txd = 16'hFEDC;
        pulse_s(2);
        pulse_m(2);
        while (m_busy || s_busy) @(negedge clk);
        repeat (8) @(negedge clk);
        pulse_m(1);
        pulse_s(1);
        chk(m_flag == 1, "R9 data read alone keeps flag", m_flag, 1);
        pulse_s(0);
        pulse_s(2);
        chk(s_flag == 0, "R9 status then tx write clears", s_flag, 0);
        pulse_m(0); pulse_m(1);
        chk(m_flag == 0, "R9 status then read clears", m_flag, 0);

        // random mix
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < 24; k++) begin
            logic [31:0] r;
            r = $urandom;
            run_xfer(r[0], r[1], r[2], r[3], 8'(6 + ($urandom % 7)), 16'($urandom), 16'($urandom));
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule